// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This block copies bytes from anywhere in a 16-bit system address space into an 8 KB video memory window based at 0x8000. Software sets up a source address, a destination address and a control byte through a small register port. The control byte picks one of two modes:

- **Immediate mode** copies the whole length in one run.
- **Paced mode** arms the engine. After that, every blank-period strobe moves one 16-byte chunk.

Both addresses are rounded down to 16-byte boundaries. The destination wraps inside the window.

Bytes move over a single memory request port with valid/ready handshaking. Each byte is one read request followed by one write request. Read data is returned combinationally in the cycle the read is accepted. The engine holds address, write flag and write data stable while valid is high and ready is low, so the memory side can stall any request for any number of cycles. After each chunk, the engine writes the advanced addresses back into the address registers, so a later chunk continues where the last one stopped. A status byte reports the remaining length, or 0xFF when nothing is pending.

Top module: `vram_dma_engine`

## Requirements
- R1: The source of a run starts at {src_hi, src_lo[7:4], 4'h0}. The low four bits written to src_lo are ignored.
- R2: Every write goes to 0x8000 | {dst_hi[4:0], dst_lo[7:4], 4'h0} plus the byte offset within the run. Every write address lies in 0x8000..0x9FFF.
- R3: A write of a control byte with bit 7 clear, while paced mode is not armed and the engine is idle, starts an immediate run. The run moves (bits 6:0 + 1) × 16 bytes in address order, and status then reads 0xFF.
- R4: Each byte is one accepted read (mem_we = 0) followed by one accepted write (mem_we = 1) carrying the data read. While mem_valid is high and mem_ready is low, mem_addr, mem_we and mem_wdata hold steady.
- R5: A control write with bit 7 set arms paced mode. Status then reads the written value with bit 7 cleared, and no byte moves until a strobe arrives.
- R6: While paced mode is armed and the engine is idle, a blank_strobe moves exactly 16 bytes. Afterwards status is one lower than before.
- R7: Paced mode disarms after length + 1 chunks. Status then reads 0xFF, and further strobes move nothing.
- R8: While paced mode is armed, any control write is stored as the new mode byte, and status reads that value with bit 7 cleared. If bit 7 is clear, this cancels paced mode, starts no run, and later strobes move nothing.
- R9: After each chunk, the address registers read back the advanced addresses. The readback is src_hi = source[15:8], src_lo = {source[7:4], 4'h0}, dst_hi = {3'b0, offset[12:8]} and dst_lo = {offset[7:4], 4'h0}.
- R10: After reset, status reads 0xFF, busy is low, mem_valid is low and the address registers read 0.
- R11: The engine ignores a blank_strobe while it is not armed. It also ignores any register write or strobe that arrives while busy is high.
- R12: A run that passes 0x9FFF continues at 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Write target: 0 src_hi, 1 src_lo, 2 dst_hi, 3 dst_lo, 4 control |
| reg_wdata | input | 8 | Register write data |
| reg_rsel | input | 3 | Readback select, same codes; 4 returns status |
| reg_rdata | output | 8 | Readback data (combinational) |
| blank_strobe | input | 1 | One-cycle pulse that requests one paced chunk |
| busy | output | 1 | High while a run is moving bytes |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted this cycle |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle a read is accepted |

## Verification
A register write or strobe that the engine accepts at a clock edge raises busy right after that edge. mem_valid is high from the following cycle onward. Each byte then needs one accepted read and one accepted write, so a chunk takes 32 cycles plus any stall cycles. Status and the address writeback change at the same edge that accepts the final write, and busy falls at that edge too.

The bench never counts cycles. It samples on falling edges, polls busy until it drops, and only then reads status and the registers. A scoreboard queue holds the expected write addresses and data, and the bench compares each accepted write against it as the write happens. Because of this, throttling ready changes no expected value.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CHUNK_LG2 = 4,
  parameter int WIN_LG2   = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_sel,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          wb_en,
  input  logic [2*DW-CHUNK_LG2-1:0]     wb_src_c,
  input  logic [WIN_LG2-CHUNK_LG2-1:0]  wb_dst_c,
  input  logic [2:0]                    rd_sel,
  input  logic [DW-1:0]                 status_in,
  output logic [2*DW-CHUNK_LG2-1:0]     src_c,
  output logic [WIN_LG2-CHUNK_LG2-1:0]  dst_c,
  output logic [DW-1:0]                 rd_data
);
  localparam int LO_W  = DW - CHUNK_LG2;
  localparam int DHI_W = WIN_LG2 - DW;
  localparam int PAD_W = DW - DHI_W;

  logic [DW-1:0]    src_hi_q;
  logic [LO_W-1:0]  src_lo_q;
  logic [DHI_W-1:0] dst_hi_q;
  logic [LO_W-1:0]  dst_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
    end else if (wb_en) begin
      src_hi_q <= wb_src_c[2*DW-CHUNK_LG2-1:LO_W];
      src_lo_q <= wb_src_c[LO_W-1:0];
      dst_hi_q <= wb_dst_c[WIN_LG2-CHUNK_LG2-1:LO_W];
      dst_lo_q <= wb_dst_c[LO_W-1:0];
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SRC_HI: src_hi_q <= wr_data;
        SEL_SRC_LO: src_lo_q <= wr_data[DW-1:CHUNK_LG2];
        SEL_DST_HI: dst_hi_q <= wr_data[DHI_W-1:0];
        SEL_DST_LO: dst_lo_q <= wr_data[DW-1:CHUNK_LG2];
        default: ;
      endcase
    end
  end

  assign src_c = {src_hi_q, src_lo_q};
  assign dst_c = {dst_hi_q, dst_lo_q};

  always_comb begin
    case (rd_sel)
      SEL_SRC_HI: rd_data = src_hi_q;
      SEL_SRC_LO: rd_data = {src_lo_q, {CHUNK_LG2{1'b0}}};
      SEL_DST_HI: rd_data = {{PAD_W{1'b0}}, dst_hi_q};
      SEL_DST_LO: rd_data = {dst_lo_q, {CHUNK_LG2{1'b0}}};
      SEL_CTRL:   rd_data = status_in;
      default:    rd_data = '1;
    endcase
  end
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CHUNK_LG2 = 4,
  parameter int WIN_LG2   = 13,
  parameter int CNT_W     = 8,
  parameter logic [2*DW-1:0] WIN_BASE = 16'h8000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [CNT_W-1:0]              nchunks,
  input  logic [2*DW-CHUNK_LG2-1:0]     src_c,
  input  logic [WIN_LG2-CHUNK_LG2-1:0]  dst_c,
  output logic                          mem_valid,
  input  logic                          mem_ready,
  output logic                          mem_we,
  output logic [2*DW-1:0]               mem_addr,
  output logic [DW-1:0]                 mem_wdata,
  input  logic [DW-1:0]                 mem_rdata,
  output logic                          busy,
  output logic                          chunk_done,
  output logic                          job_done,
  output logic [2*DW-CHUNK_LG2-1:0]     next_src_c,
  output logic [WIN_LG2-CHUNK_LG2-1:0]  next_dst_c
);
  localparam int AW = 2 * DW;

  seq_state_e             state;
  logic [AW-1:0]          src_q;
  logic [WIN_LG2-1:0]     dst_off;
  logic [CHUNK_LG2-1:0]   byte_idx;
  logic [CNT_W-1:0]       chunks_left;
  logic [DW-1:0]          data_q;
  logic                   step;
  logic                   last_byte;

  assign step       = (state == ST_WR) && mem_ready;
  assign last_byte  = &byte_idx;
  assign chunk_done = step && last_byte;
  assign job_done   = chunk_done && (chunks_left == CNT_W'(1));
  assign next_src_c = src_q[AW-1:CHUNK_LG2] + 1'b1;
  assign next_dst_c = dst_off[WIN_LG2-1:CHUNK_LG2] + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      src_q       <= '0;
      dst_off     <= '0;
      byte_idx    <= '0;
      chunks_left <= '0;
      data_q      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state       <= ST_RD;
          src_q       <= {src_c, {CHUNK_LG2{1'b0}}};
          dst_off     <= {dst_c, {CHUNK_LG2{1'b0}}};
          byte_idx    <= '0;
          chunks_left <= nchunks;
        end
        ST_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          state  <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          src_q    <= src_q + 1'b1;
          dst_off  <= dst_off + 1'b1;
          byte_idx <= byte_idx + 1'b1;
          if (last_byte) begin
            chunks_left <= chunks_left - 1'b1;
            state <= (chunks_left == CNT_W'(1)) ? ST_IDLE : ST_RD;
          end else begin
            state <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_valid = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_wdata = data_q;
  assign mem_addr  = (state == ST_WR)
                     ? (WIN_BASE | {{(AW-WIN_LG2){1'b0}}, dst_off})
                     : src_q;

  // R4: request held steady while stalled
  p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R4: accepted read is followed by a write carrying the returned data
  p_data_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_we |=> mem_valid && mem_we && (mem_wdata == $past(mem_rdata)));

  // R2: writes stay in the window
  p_dst_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> (mem_addr[AW-1:WIN_LG2] == WIN_BASE[AW-1:WIN_LG2]));

  // R1: first read of every chunk is aligned
  p_chunk_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we && (byte_idx == '0) |-> (mem_addr[CHUNK_LG2-1:0] == '0));
endmodule

// File: rtl/vdma_mode.sv
module vdma_mode #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [DW-1:0] ctrl_wdata,
  input  logic          strobe,
  input  logic          busy,
  input  logic          chunk_done,
  input  logic          job_done,
  output logic          start,
  output logic [DW-1:0] nchunks,
  output logic [DW-1:0] status
);
  localparam int LEN_W = DW - 1;

  logic [DW-1:0] mode_q;
  logic [DW-1:0] status_q;
  logic          gen_run;
  logic          armed;
  logic          gen_start;
  logic          blk_start;

  assign armed     = mode_q[DW-1];
  assign gen_start = ctrl_we && !armed && !ctrl_wdata[DW-1] && !busy;
  assign blk_start = strobe && armed && !ctrl_we && !busy;
  assign start     = gen_start || blk_start;
  assign nchunks   = gen_start ? ({1'b0, ctrl_wdata[LEN_W-1:0]} + 1'b1) : DW'(1);
  assign status    = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      status_q <= '1;
      gen_run  <= 1'b0;
    end else if (ctrl_we && !busy) begin
      if (armed || ctrl_wdata[DW-1]) begin
        mode_q   <= ctrl_wdata;
        status_q <= {1'b0, ctrl_wdata[LEN_W-1:0]};
      end else begin
        gen_run <= 1'b1;
      end
    end else if (chunk_done) begin
      if (gen_run) begin
        if (job_done) begin
          status_q <= '1;
          gen_run  <= 1'b0;
        end
      end else begin
        status_q <= status_q - 1'b1;
        mode_q   <= mode_q - 1'b1;
      end
    end
  end

  // R11: nothing starts while a run is in flight
  p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  // R3: an immediate run ends idle with status 0xFF
  p_gen_ends_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    job_done && gen_run |=> (status == '1) && !busy);
endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine
  import vdma_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CHUNK_LG2 = 4,
  parameter int WIN_LG2   = 13,
  parameter logic [2*DW-1:0] WIN_BASE = 16'h8000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [2:0]      reg_rsel,
  output logic [DW-1:0]   reg_rdata,
  input  logic            blank_strobe,
  output logic            busy,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int AW    = 2 * DW;
  localparam int SRC_W = AW - CHUNK_LG2;
  localparam int DST_W = WIN_LG2 - CHUNK_LG2;

  logic             wr_ok;
  logic             ctrl_we;
  logic             addr_we;
  logic [SRC_W-1:0] src_c, next_src_c;
  logic [DST_W-1:0] dst_c, next_dst_c;
  logic [DW-1:0]    status;
  logic [DW-1:0]    nchunks;
  logic             start, chunk_done, job_done;

  assign wr_ok   = reg_we && !busy;
  assign ctrl_we = wr_ok && (reg_sel == SEL_CTRL);
  assign addr_we = wr_ok && (reg_sel != SEL_CTRL);

  vdma_regs #(.DW(DW), .CHUNK_LG2(CHUNK_LG2), .WIN_LG2(WIN_LG2)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(addr_we), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .wb_en(chunk_done), .wb_src_c(next_src_c), .wb_dst_c(next_dst_c),
    .rd_sel(reg_rsel), .status_in(status),
    .src_c(src_c), .dst_c(dst_c), .rd_data(reg_rdata)
  );

  vdma_mode #(.DW(DW)) mode_i (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(reg_wdata), .strobe(blank_strobe),
    .busy(busy), .chunk_done(chunk_done), .job_done(job_done),
    .start(start), .nchunks(nchunks), .status(status)
  );

  vdma_seq #(.DW(DW), .CHUNK_LG2(CHUNK_LG2), .WIN_LG2(WIN_LG2),
             .CNT_W(DW), .WIN_BASE(WIN_BASE)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start(start), .nchunks(nchunks), .src_c(src_c), .dst_c(dst_c),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .chunk_done(chunk_done), .job_done(job_done),
    .next_src_c(next_src_c), .next_dst_c(next_dst_c)
  );
endmodule

// File: tb/vram_dma_engine_tb_top.sv
module vram_dma_engine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [2:0]  reg_rsel = '0;
  logic [7:0]  reg_rdata;
  logic        blank_strobe = 1'b0;
  logic        busy;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_a[$];
  logic [7:0]  exp_d[$];
  logic [2:0]  rcnt = '0;

  vram_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .blank_strobe(blank_strobe), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] src_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign mem_rdata = src_fn(mem_addr);

  // memory side back-pressure: two stall cycles in every eight
  always @(posedge clk) begin
    rcnt      <= rcnt + 1'b1;
    mem_ready <= (rcnt != 3'd2) && (rcnt != 3'd5);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare each accepted write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready && mem_we) begin
      if (exp_a.size() == 0) begin
        check(1'b0, "R11 unexpected write", {16'h0, mem_addr}, 32'h0);
      end else begin
        logic [15:0] ea;
        logic [7:0]  ed;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        check(mem_addr == ea, "R2/R12 write address", {16'h0, mem_addr}, {16'h0, ea});
        check(mem_wdata == ed, "R1/R4 write data", {24'h0, mem_wdata}, {24'h0, ed});
      end
    end
  end

  task automatic push_run(input logic [15:0] src, input logic [12:0] off, input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      logic [12:0] o;
      o = off + 13'(i);
      exp_a.push_back(16'h8000 | {3'b000, o});
      exp_d.push_back(src_fn(src + 16'(i)));
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    reg_rsel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic strobe_pulse();
    blank_strobe = 1'b1;
    @(negedge clk);
    blank_strobe = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic expect_reg(input logic [2:0] sel, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(sel, v);
    check(v == e, req, {24'h0, v}, {24'h0, e});
  endtask

  task automatic expect_quiet(input string req);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!busy, req, {31'h0, busy}, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    expect_reg(3'd4, 8'hFF, "R10 status after reset");
    expect_reg(3'd0, 8'h00, "R10 src_hi after reset");
    check(!busy && !mem_valid, "R10 idle after reset", {30'h0, busy, mem_valid}, 32'h0);

    // R11 strobe while not armed
    strobe_pulse();
    expect_quiet("R11 idle strobe ignored");

    // R3 immediate run, unaligned low bytes (R1, R2)
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'hE3); wr(3'd3, 8'h47);
    push_run(16'h1230, 13'h0340, 48);
    wr(3'd4, 8'h02);
    check(busy, "R3 run started", {31'h0, busy}, 32'h1);
    wr(3'd4, 8'h00);   // R11 ignored while busy
    wr(3'd0, 8'hAA);   // R11 ignored while busy
    wait_idle();
    check(exp_a.size() == 0, "R3 byte count", exp_a.size(), 32'h0);
    expect_reg(3'd4, 8'hFF, "R3 status after run");
    expect_reg(3'd0, 8'h12, "R9 src_hi writeback");
    expect_reg(3'd1, 8'h60, "R9 src_lo writeback");
    expect_reg(3'd2, 8'h03, "R9 dst_hi writeback");
    expect_reg(3'd3, 8'h70, "R9 dst_lo writeback");
    expect_quiet("R11 control write during run ignored");

    // R12 wrap at the top of the window
    wr(3'd0, 8'h40); wr(3'd1, 8'h0F); wr(3'd2, 8'h1F); wr(3'd3, 8'hE0);
    push_run(16'h4000, 13'h1FE0, 64);
    wr(3'd4, 8'h03);
    wait_idle();
    check(exp_a.size() == 0, "R12 byte count", exp_a.size(), 32'h0);
    expect_reg(3'd2, 8'h00, "R12 dst_hi after wrap");
    expect_reg(3'd3, 8'h20, "R12 dst_lo after wrap");
    expect_reg(3'd0, 8'h40, "R9 src_hi after wrap run");
    expect_reg(3'd1, 8'h40, "R9 src_lo after wrap run");

    // R5 arm paced mode
    wr(3'd0, 8'h21); wr(3'd1, 8'h00); wr(3'd2, 8'h08); wr(3'd3, 8'h00);
    wr(3'd4, 8'h82);
    expect_reg(3'd4, 8'h02, "R5 status after arm");
    expect_quiet("R5 arm moves nothing");

    // R6/R7 three chunks
    for (int k = 0; k < 3; k++) begin
      logic [7:0] es;
      push_run(16'h2100 + 16'(16 * k), 13'h0800 + 13'(16 * k), 16);
      strobe_pulse();
      wait_idle();
      check(exp_a.size() == 0, "R6 chunk of 16 bytes", exp_a.size(), 32'h0);
      es = 8'h01 - 8'(k);
      expect_reg(3'd4, es, "R6/R7 status per chunk");
    end
    strobe_pulse();
    expect_quiet("R7 strobe after last chunk ignored");
    expect_reg(3'd4, 8'hFF, "R7 status after disarm");

    // R8 cancel
    wr(3'd4, 8'h85);
    expect_reg(3'd4, 8'h05, "R5 status after second arm");
    push_run(16'h2130, 13'h0830, 16);
    strobe_pulse();
    wait_idle();
    expect_reg(3'd4, 8'h04, "R6 status after one chunk");
    expect_reg(3'd1, 8'h40, "R9 src_lo after paced chunk");
    wr(3'd4, 8'h03);
    expect_reg(3'd4, 8'h03, "R8 status after cancel");
    expect_quiet("R8 cancel starts no run");
    strobe_pulse();
    expect_quiet("R8 strobe after cancel ignored");
    expect_reg(3'd4, 8'h03, "R8 status unchanged");

    check(exp_a.size() == 0, "R4 scoreboard drained", exp_a.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule